// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit performs one packed integer operation per accepted request on 128-bit source vectors. Every request carries a 12-bit control word, so each operation sets its own vector width, lane width, overflow policy and operator. No vector-type state is kept between requests. The unit splits the operands into 8-, 16-, 32- or 64-bit lanes. It applies add, subtract, low multiply, multiply-accumulate or high multiply to every lane, and it either wraps or clamps on overflow. Clamping can be signed or unsigned.

A request is accepted when `in_valid` is high. Exactly one clock later the registered result appears with `out_valid`. Two flags come with it. One reports an operator code the unit does not implement. The other reports a control combination the unit does not support: the float category or a reserved vector width. Both cases return an all-zero result. When no request is accepted, the output registers keep their last values.

Top module: `simd_pack_alu`

## Requirements
- R1: The control word is split as: bits [1:0] vector width (0 = 64-bit, 1 = 128-bit, 2 and 3 reserved), bits [3:2] lane width (0/1/2/3 = 8/16/32/64 bits), bits [5:4] category (0 = wrap, 1 = float, 2 = signed saturate, 3 = unsigned saturate), bits [11:6] operator (0 = add, 1 = sub, 2 = mul low, 3 = mac, 4 = mulhi). Each lane is computed independently of its neighbours.
- R2: In the wrap category, add, sub, mul and mac return the low lane-width bits of the exact result.
- R3: In the signed-saturate category, add, sub, mul and mac treat lanes as two's complement and clamp to the most positive or most negative value of the lane width.
- R4: In the unsigned-saturate category, add, sub, mul and mac treat lanes as unsigned, clamp to all-ones on overflow and clamp to zero on underflow.
- R5: mul returns the low half of the lane product, and mac adds the accumulator lane to the full lane product before wrapping or clamping.
- R6: mulhi returns the upper lane-width bits of the double-width product. It is signed for categories 0 and 2, unsigned for category 3, and never saturated.
- R7: With vector width 0, result bits [127:64] are zero and only the low 64 bits are computed.
- R8: The float category or a vector width of 2 or 3 sets `unsupported`, clears `illegal` and gives a zero result.
- R9: On a supported request, an operator code above 4 sets `illegal` and gives a zero result.
- R10: `out_valid` follows `in_valid` by exactly one clock, and result and flags are updated in that same cycle. A synchronous active-high reset clears `out_valid`, `result` and both flags.
- R11: While `in_valid` is low, `result`, `illegal` and `unsupported` keep their values and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request accepted on this edge |
| ctrl | input | 12 | Per-request control word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| src_acc | input | 128 | Accumulator vector for mac |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered packed result |
| illegal | output | 1 | Operator code not implemented |
| unsupported | output | 1 | Float category or reserved vector width |

## Verification
Each result, the two flags and `out_valid` are due at the first rising edge after the edge that accepted the request, because the only register on the path is the output stage. The bench drives a request on a falling edge, drops `in_valid` at the next falling edge and samples everything there, half a period after the capturing edge. It then waits one more falling edge with no request and checks that the outputs have held and `out_valid` has dropped.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int CTRL_W = 12;

  localparam logic [1:0] CAT_WRAP  = 2'd0;
  localparam logic [1:0] CAT_FLOAT = 2'd1;
  localparam logic [1:0] CAT_SSAT  = 2'd2;
  localparam logic [1:0] CAT_USAT  = 2'd3;

  localparam logic [2:0] OPS_ADD   = 3'd0;
  localparam logic [2:0] OPS_SUB   = 3'd1;
  localparam logic [2:0] OPS_MUL   = 3'd2;
  localparam logic [2:0] OPS_MAC   = 3'd3;
  localparam logic [2:0] OPS_MULHI = 3'd4;
  localparam logic [5:0] OP_LAST   = 6'd4;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] cat;
    logic [1:0] esize;
    logic [1:0] vsize;
  } simd_ctrl_t;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [1:0]   cat,
  input  logic [2:0]   opsel,
  output logic [W-1:0] y
);
  localparam int P = 2 * W;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W:0]   s_add, u_add, s_sub, u_sub;
  logic [P-1:0] ax_s, bx_s, ax_u, bx_u, ps, pu;
  logic [P:0]   m_s, m_u;
  logic [W:0]   ps_top;
  logic [W+1:0] ms_top;
  logic         ps_ovf, ms_ovf;

  assign s_add = {a[W-1], a} + {b[W-1], b};
  assign u_add = {1'b0, a} + {1'b0, b};
  assign s_sub = {a[W-1], a} - {b[W-1], b};
  assign u_sub = {1'b0, a} - {1'b0, b};

  assign ax_s = {{W{a[W-1]}}, a};
  assign bx_s = {{W{b[W-1]}}, b};
  assign ax_u = {{W{1'b0}}, a};
  assign bx_u = {{W{1'b0}}, b};
  assign ps   = ax_s * bx_s;
  assign pu   = ax_u * bx_u;

  assign m_s = {ps[P-1], ps} + {{(W+1){c[W-1]}}, c};
  assign m_u = {1'b0, pu} + {{(W+1){1'b0}}, c};

  assign ps_top = ps[P-1:W-1];
  assign ms_top = m_s[P:W-1];
  assign ps_ovf = !((&ps_top) || !(|ps_top));
  assign ms_ovf = !((&ms_top) || !(|ms_top));

  always_comb begin
    y = '0;
    unique case (opsel)
      OPS_ADD: begin
        if (cat == CAT_SSAT)
          y = (s_add[W] ^ s_add[W-1]) ? (s_add[W] ? SMIN : SMAX) : s_add[W-1:0];
        else if (cat == CAT_USAT)
          y = u_add[W] ? UMAX : u_add[W-1:0];
        else
          y = u_add[W-1:0];
      end
      OPS_SUB: begin
        if (cat == CAT_SSAT)
          y = (s_sub[W] ^ s_sub[W-1]) ? (s_sub[W] ? SMIN : SMAX) : s_sub[W-1:0];
        else if (cat == CAT_USAT)
          y = u_sub[W] ? '0 : u_sub[W-1:0];
        else
          y = s_sub[W-1:0];
      end
      OPS_MUL: begin
        if (cat == CAT_SSAT)
          y = ps_ovf ? (ps[P-1] ? SMIN : SMAX) : ps[W-1:0];
        else if (cat == CAT_USAT)
          y = (|pu[P-1:W]) ? UMAX : pu[W-1:0];
        else
          y = ps[W-1:0];
      end
      OPS_MAC: begin
        if (cat == CAT_SSAT)
          y = ms_ovf ? (m_s[P] ? SMIN : SMAX) : m_s[W-1:0];
        else if (cat == CAT_USAT)
          y = (|m_u[P:W]) ? UMAX : m_u[W-1:0];
        else
          y = m_s[W-1:0];
      end
      OPS_MULHI: begin
        y = (cat == CAT_USAT) ? pu[P-1:W] : ps[P-1:W];
      end
      default: y = '0;
    endcase
    if (cat == CAT_FLOAT) y = '0;
  end
endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  input  logic [1:0]        cat,
  input  logic [2:0]        opsel,
  output logic [DATA_W-1:0] y
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    simd_lane_op #(.W(LANE_W)) u_lane (
      .a     (a[i*LANE_W +: LANE_W]),
      .b     (b[i*LANE_W +: LANE_W]),
      .c     (c[i*LANE_W +: LANE_W]),
      .cat   (cat),
      .opsel (opsel),
      .y     (y[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_result_sel.sv
module simd_result_sel #(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64,
  parameter int NUM_ESZ  = 4,
  localparam int ESZ_W   = $clog2(NUM_ESZ)
) (
  input  logic [NUM_ESZ-1:0][DATA_W-1:0] slices,
  input  logic [ESZ_W-1:0]               esize,
  input  logic                           narrow,
  input  logic                           kill,
  output logic [DATA_W-1:0]              y
);
  always_comb begin
    y = slices[esize];
    if (narrow) y[DATA_W-1:NARROW_W] = '0;
    if (kill) y = '0;
  end
endmodule

// File: rtl/simd_pack_alu.sv
module simd_pack_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64,
  parameter int MIN_LANE = 8,
  parameter int NUM_ESZ  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [11:0]       ctrl,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_acc,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal,
  output logic              unsupported
);
  simd_ctrl_t cw;
  logic       unsup_c, illeg_c;
  logic [NUM_ESZ-1:0][DATA_W-1:0] slice_y;
  logic [DATA_W-1:0] sel_y;

  assign cw      = simd_ctrl_t'(ctrl);
  assign unsup_c = (cw.cat == CAT_FLOAT) || cw.vsize[1];
  assign illeg_c = !unsup_c && (cw.op > OP_LAST);

  for (genvar k = 0; k < NUM_ESZ; k++) begin : g_esz
    simd_width_slice #(.DATA_W(DATA_W), .LANE_W(MIN_LANE << k)) u_slice (
      .a     (src_a),
      .b     (src_b),
      .c     (src_acc),
      .cat   (cw.cat),
      .opsel (cw.op[2:0]),
      .y     (slice_y[k])
    );
  end

  simd_result_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .NUM_ESZ(NUM_ESZ)) u_sel (
    .slices (slice_y),
    .esize  (cw.esize),
    .narrow (cw.vsize == 2'd0),
    .kill   (unsup_c || illeg_c),
    .y      (sel_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      illegal     <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= sel_y;
        illegal     <= illeg_c;
        unsupported <= unsup_c;
      end
    end
  end
endmodule

// File: rtl/simd_pack_alu_chk.sv
module simd_pack_alu_chk #(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [11:0]       ctrl,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal,
  input logic              unsupported
);
  a_r10_valid_from_request: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  a_r10_request_gives_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ctrl[1:0]) == 2'd0) |-> result[DATA_W-1:NARROW_W] == '0);
  a_r8_float_flagged: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ctrl[5:4]) == 2'd1) |-> (unsupported && !illegal));
  a_r8_unsup_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && unsupported) |-> result == '0);
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0 && !unsupported));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal) && $stable(unsupported)));
endmodule

bind simd_pack_alu simd_pack_alu_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl), .out_valid(out_valid),
  .result(result), .illegal(illegal), .unsupported(unsupported)
);

// File: tb/simd_pack_alu_test.sv
module simd_pack_alu_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [11:0]  ctrl = '0;
  logic [127:0] src_a = '0, src_b = '0, src_acc = '0;
  logic         out_valid, illegal, unsupported;
  logic [127:0] result;
  int total = 0;
  int bad = 0;
  logic         done = 1'b0;

  always #4 clk = ~clk;

  simd_pack_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl), .src_a(src_a),
    .src_b(src_b), .src_acc(src_acc), .out_valid(out_valid), .result(result),
    .illegal(illegal), .unsupported(unsupported)
  );

  function automatic logic signed [131:0] to_num(logic [63:0] v, int w, bit sgn);
    logic signed [131:0] x;
    x = $signed({68'd0, v});
    if (sgn && v[w-1]) x = x - (132'sd1 <<< w);
    return x;
  endfunction

  function automatic logic [63:0] lane_ref(int w, logic [63:0] a, logic [63:0] b,
                                           logic [63:0] c, logic [1:0] cat, logic [5:0] op);
    logic signed [131:0] sa, sb, sc, x, hi, lo;
    logic [63:0] m;
    bit sgn;
    sgn = (cat != 2'd3);
    sa = to_num(a, w, sgn);
    sb = to_num(b, w, sgn);
    sc = to_num(c, w, sgn);
    case (op)
      6'd0: x = sa + sb;
      6'd1: x = sa - sb;
      6'd2: x = sa * sb;
      6'd3: x = sa * sb + sc;
      default: x = (sa * sb) >>> w;
    endcase
    if (op != 6'd4 && cat != 2'd0) begin
      if (cat == 2'd2) begin
        hi = (132'sd1 <<< (w - 1)) - 132'sd1;
        lo = -(132'sd1 <<< (w - 1));
      end else begin
        hi = (132'sd1 <<< w) - 132'sd1;
        lo = 132'sd0;
      end
      if (x > hi) x = hi;
      if (x < lo) x = lo;
    end
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    return x[63:0] & m;
  endfunction

  function automatic void vec_ref(logic [11:0] cw, logic [127:0] a, logic [127:0] b,
                                  logic [127:0] c, output logic [127:0] r,
                                  output logic il, output logic un);
    int w, n;
    logic [63:0] la, lb, lc, m, ly;
    un = (cw[1:0] >= 2'd2) || (cw[5:4] == 2'd1);
    il = !un && (cw[11:6] > 6'd4);
    r = '0;
    if (!un && !il) begin
      w = 8 << cw[3:2];
      n = ((cw[1:0] == 2'd0) ? 64 : 128) / w;
      m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      for (int i = 0; i < n; i++) begin
        la = 64'(a >> (i * w)) & m;
        lb = 64'(b >> (i * w)) & m;
        lc = 64'(c >> (i * w)) & m;
        ly = lane_ref(w, la, lb, lc, cw[5:4], cw[11:6]);
        r = r | ({64'd0, ly} << (i * w));
      end
    end
  endfunction

  task automatic check(string tag, logic ok, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [11:0] cw, logic [127:0] a,
                        logic [127:0] b, logic [127:0] c);
    logic [127:0] er, held;
    logic eil, eun;
    vec_ref(cw, a, b, c, er, eil, eun);
    @(negedge clk);
    in_valid = 1'b1; ctrl = cw; src_a = a; src_b = b; src_acc = c;
    @(negedge clk);
    in_valid = 1'b0; ctrl = $urandom; src_a = {4{$urandom}}; src_b = {4{$urandom}};
    check({tag, " R10 out_valid"}, out_valid === 1'b1, {127'd0, out_valid}, 128'd1);
    check({tag, " result"}, result === er, result, er);
    check({tag, " flags"}, {illegal, unsupported} === {eil, eun},
          {126'd0, illegal, unsupported}, {126'd0, eil, eun});
    held = result;
    @(negedge clk);
    check({tag, " R11 hold"}, result === held && out_valid === 1'b0
          && {illegal, unsupported} === {eil, eun}, result, held);
  endtask

  function automatic logic [11:0] mk(logic [1:0] vs, logic [1:0] es, logic [1:0] ct,
                                     logic [5:0] op);
    return {op, ct, es, vs};
  endfunction

  function automatic logic [127:0] rnd_opnd();
    case ($urandom % 6)
      0: return {16{8'h7f}};
      1: return {16{8'h80}};
      2: return '1;
      default: return {$urandom, $urandom, $urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] cw;
    logic [1:0]  vs;
    logic [5:0]  op;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", out_valid === 1'b0 && result === '0 && illegal === 1'b0
          && unsupported === 1'b0, result, 128'd0);

    run_op("R2 wrap add 8b", mk(2'd1, 2'd0, 2'd0, 6'd0), '1, {16{8'h01}}, '0);
    check("R2 wrap add wraps to zero", result === '0, result, 128'd0);
    run_op("R3 ssat add 8b", mk(2'd1, 2'd0, 2'd2, 6'd0), {16{8'h7f}}, {16{8'h01}}, '0);
    check("R3 ssat clamp to max", result === {16{8'h7f}}, result, {16{8'h7f}});
    run_op("R3 ssat sub 16b", mk(2'd1, 2'd1, 2'd2, 6'd1), {8{16'h8000}}, {8{16'h0001}}, '0);
    check("R3 ssat clamp to min", result === {8{16'h8000}}, result, {8{16'h8000}});
    run_op("R4 usat sub 32b", mk(2'd1, 2'd2, 2'd3, 6'd1), '0, {4{32'd5}}, '0);
    check("R4 usat underflow to zero", result === '0, result, 128'd0);
    run_op("R4 usat mul 64b", mk(2'd1, 2'd3, 2'd3, 6'd2), '1, {2{64'd2}}, '0);
    check("R4 usat overflow to ones", result === '1, result, '1);
    run_op("R5 mac 16b", mk(2'd1, 2'd1, 2'd0, 6'd3), {8{16'd3}}, {8{16'd4}}, {8{16'd10}});
    check("R5 mac value", result === {8{16'd22}}, result, {8{16'd22}});
    run_op("R6 mulhi signed 8b", mk(2'd1, 2'd0, 2'd0, 6'd4), {16{8'hff}}, {16{8'h02}}, '0);
    check("R6 mulhi signed", result === '1, result, '1);
    run_op("R6 mulhi unsigned 8b", mk(2'd1, 2'd0, 2'd3, 6'd4), {16{8'hff}}, {16{8'h02}}, '0);
    check("R6 mulhi unsigned", result === {16{8'h01}}, result, {16{8'h01}});
    run_op("R7 narrow 32b add", mk(2'd0, 2'd2, 2'd0, 6'd0), '1, '1, '0);
    check("R7 upper zero", result[127:64] === '0, result, {64'd0, {2{32'hfffffffe}}});
    run_op("R8 float", mk(2'd1, 2'd2, 2'd1, 6'd0), '1, '1, '1);
    check("R8 float flag", unsupported === 1'b1 && result === '0, result, 128'd0);
    run_op("R8 reserved vsize", mk(2'd3, 2'd0, 2'd0, 6'd0), '1, '1, '1);
    run_op("R9 illegal op", mk(2'd1, 2'd0, 2'd0, 6'd9), '1, '1, '1);
    check("R9 illegal flag", illegal === 1'b1 && result === '0, result, 128'd0);
    run_op("R1 lane independence 64b", mk(2'd1, 2'd3, 2'd0, 6'd0),
           {64'd1, 64'hffffffffffffffff}, {64'd0, 64'd1}, '0);
    check("R1 no carry across lanes", result === {64'd1, 64'd0}, result, {64'd1, 64'd0});

    for (int t = 0; t < 600; t++) begin
      vs = ($urandom % 10 == 0) ? 2'($urandom) : 2'($urandom % 2);
      op = ($urandom % 12 == 0) ? 6'($urandom) : 6'($urandom % 5);
      cw = mk(vs, 2'($urandom), 2'($urandom), op);
      run_op("R1 R2 R3 R4 R5 R6 random", cw, rnd_opnd(), rnd_opnd(), rnd_opnd());
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule